// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two component predictors run side by side. The first is a global-history predictor: a table of 2-bit counters indexed by the outcomes of the most recent 12 resolved branches. The second is a two-stage local predictor. It first reads a 10-bit history, kept separately for each branch, from a table indexed by the branch address. It then uses that history to pick a 3-bit counter. A third table of 2-bit counters, indexed by the branch address, decides for each branch which component supplies the final direction.

A fetch stage presents a PC on the predict port. In the same cycle it receives the final direction, both component directions and the chooser's selection. When a branch resolves, the back end presents the branch PC, its real outcome and the two component directions that were issued for it. All tables and histories change on the next clock edge. Both histories are non-speculative. Target prediction and recovery of speculative state are not part of this block. With default parameters the block holds 4096×2 + 4096×2 + 1024×10 + 1024×3 bits, which is 29 Kbits.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every global counter is 1 and every local counter is 3, which are both weakly not taken. Every chooser counter is 1 (weakly local), and the global history and all local histories are zero. As a result every PC predicts not taken, with `pred_use_global` low.
- R2: `pred_global` is 1 exactly when the 2-bit global counter indexed by the current 12-bit global history holds 2 or more.
- R3: `pred_local` is 1 exactly when the 3-bit local counter indexed by the 10-bit history stored at local-table entry `pred_pc[11:2]` holds 4 or more.
- R4: The chooser entry is selected by `pred_pc[13:2]`. A value of 2 or more drives `pred_use_global` high and makes `pred_taken` equal `pred_global`. A lower value makes `pred_taken` equal `pred_local`.
- R5: On an update where `upd_global_pred` differs from `upd_local_pred`, the chooser entry at `upd_pc[13:2]` steps by one toward global if `upd_global_pred` equals `upd_taken`, and toward local otherwise. When the two predictions agree, the chooser entry is unchanged.
- R6: Every valid update trains the global counter at the current history and the local counter at the history read from entry `upd_pc[11:2]`. Each counter steps up on taken and down on not taken.
- R7: After each valid update, the global history shifts left by one and the outcome enters at bit 0.
- R8: After each valid update, only local-table entry `upd_pc[11:2]` shifts left by one, with the outcome entering at bit 0. All other entries keep their value.
- R9: Counters saturate. A counter at its maximum (3 for 2-bit, 7 for 3-bit) stays there on taken, and a counter at 0 stays at 0 on not taken.
- R10: Predictions made in the same cycle as an update use the state from before that update. The update becomes visible from the next cycle on.
- R11: While `upd_valid` is low, the update inputs have no effect on any table or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_pc | input | 32 | PC of the branch to predict |
| pred_taken | output | 1 | Final predicted direction |
| pred_global | output | 1 | Global component direction |
| pred_local | output | 1 | Local component direction |
| pred_use_global | output | 1 | Chooser selects the global component |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_global_pred | input | 1 | Global direction that was issued for this branch |
| upd_local_pred | input | 1 | Local direction that was issued for this branch |

## Verification
The chooser properties assume that the component directions returned on the update port are plain bits the block trusts. The block never checks them against its own tables, so the assertions only relate chooser motion to what was supplied. To exercise both the consistent and the inconsistent cases, the stimulus mostly returns the directions a reference model would have issued for that PC, and sometimes returns random bits. The history-shift and counter-step properties assume that at most one update arrives per cycle, which the single update port guarantees. The stimulus also holds `pred_pc` equal to `upd_pc` in many cycles, so that the properties that compare the same chooser entry across an update are exercised often.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

  // One saturating step of a counter of width w (w <= 8)
  function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up, input int unsigned w);
    logic [7:0] top;
    top = 8'((1 << w) - 1);
    if (up) return (v == top) ? v : v + 8'd1;
    else    return (v == 8'd0) ? v : v - 8'd1;
  endfunction

  // Counter value maps to "taken" when in the upper half of its range
  function automatic logic ctr_taken(input logic [7:0] v, input int unsigned w);
    return v >= 8'(1 << (w - 1));
  endfunction

  // Weak-not-taken reset value for a counter of width w
  function automatic int unsigned weak_low(input int unsigned w);
    return (1 << (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table import tbp_pkg::*; #(
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned CNT_W   = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CMAX = CNT_W'((1 << CNT_W) - 1);
  localparam logic [CNT_W-1:0] CRST = CNT_W'(RST_VAL);

  logic [CNT_W-1:0] mem [DEPTH];

  logic [CNT_W-1:0] wr_old;
  logic [CNT_W-1:0] wr_new;
  logic             wr_at_max;
  logic             wr_at_min;

  assign wr_old    = mem[wr_idx];
  assign wr_new    = CNT_W'(sat_step(8'(wr_old), wr_up, CNT_W));
  assign wr_at_max = (wr_old == CMAX);
  assign wr_at_min = (wr_old == '0);
  assign rd_taken  = ctr_taken(8'(mem[rd_idx]), CNT_W);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CRST;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_new;
    end
  end

  // R9: saturation at both ends
  assert_sat_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up && wr_at_max) |=> mem[$past(wr_idx)] == CMAX);
  assert_sat_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up && wr_at_min) |=> mem[$past(wr_idx)] == '0);
  // R6: training moves the counter in the direction of the outcome
  assert_train_dir_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_up) |=> mem[$past(wr_idx)] >= $past(wr_old));
  assert_train_dir_dn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_up) |=> mem[$past(wr_idx)] <= $past(wr_old));

endmodule

// File: rtl/tbp_ghist.sv
module tbp_ghist #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         shift_bit,
  output logic [W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[W-2:0], shift_bit};
  end

  // R7: newest outcome at bit 0, older outcomes move up
  assert_ghist_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(shift_bit)) && (hist[W-1:1] == $past(hist[W-2:0])));
  // R11: no shift without a valid update
  assert_ghist_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));

endmodule

// File: rtl/tbp_lht.sv
module tbp_lht #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  up_idx,
  output logic [HIST_W-1:0] up_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist = mem[rd_idx];
  assign up_hist = mem[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[up_idx] <= {up_hist[HIST_W-2:0], wr_bit};
    end
  end

  // R8: the updated entry takes the shifted history
  assert_lhist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(up_idx)] == {$past(up_hist[HIST_W-2:0]), $past(wr_bit)});
  // R8: an entry other than the updated one keeps its value
  assert_lhist_other_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx != up_idx) |=> mem[$past(rd_idx)] == $past(rd_hist));

endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor import tbp_pkg::*; #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned GHIST_W  = 12,
  parameter int unsigned CHOOSE_W = 12,
  parameter int unsigned LHT_W    = 10,
  parameter int unsigned LHIST_W  = 10,
  parameter int unsigned GCNT_W   = 2,
  parameter int unsigned LCNT_W   = 3,
  parameter int unsigned CCNT_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pred_pc,
  output logic            pred_taken,
  output logic            pred_global,
  output logic            pred_local,
  output logic            pred_use_global,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic            upd_global_pred,
  input  logic            upd_local_pred
);
  localparam int unsigned CIDX_HI  = PC_LSB + CHOOSE_W - 1;
  localparam int unsigned LIDX_HI  = PC_LSB + LHT_W - 1;
  localparam int unsigned GRST     = weak_low(GCNT_W);
  localparam int unsigned LRST     = weak_low(LCNT_W);
  localparam int unsigned CRST     = weak_low(CCNT_W);

  // Index extraction
  logic [CHOOSE_W-1:0] pred_cidx, upd_cidx;
  logic [LHT_W-1:0]    pred_lidx, upd_lidx;
  assign pred_cidx = pred_pc[CIDX_HI:PC_LSB];
  assign upd_cidx  = upd_pc[CIDX_HI:PC_LSB];
  assign pred_lidx = pred_pc[LIDX_HI:PC_LSB];
  assign upd_lidx  = upd_pc[LIDX_HI:PC_LSB];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:CIDX_HI+1], pred_pc[PC_LSB-1:0],
                            upd_pc[PC_W-1:CIDX_HI+1], upd_pc[PC_LSB-1:0]};

  // Named internal events
  logic comp_disagree;
  logic chooser_train;
  logic global_was_right;
  assign comp_disagree    = upd_global_pred != upd_local_pred;
  assign chooser_train    = upd_valid && comp_disagree;
  assign global_was_right = upd_global_pred == upd_taken;

  // Global history and global counters
  logic [GHIST_W-1:0] ghist;
  tbp_ghist #(.W(GHIST_W)) u_ghist (
    .clk(clk), .rst_n(rst_n), .shift_en(upd_valid), .shift_bit(upd_taken), .hist(ghist)
  );

  tbp_ctr_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .RST_VAL(GRST)) u_gtab (
    .clk(clk), .rst_n(rst_n), .rd_idx(ghist), .rd_taken(pred_global),
    .wr_en(upd_valid), .wr_idx(ghist), .wr_up(upd_taken)
  );

  // Local history table and local counters
  logic [LHIST_W-1:0] pred_lhist, upd_lhist;
  tbp_lht #(.IDX_W(LHT_W), .HIST_W(LHIST_W)) u_lht (
    .clk(clk), .rst_n(rst_n), .rd_idx(pred_lidx), .rd_hist(pred_lhist),
    .up_idx(upd_lidx), .up_hist(upd_lhist), .wr_en(upd_valid), .wr_bit(upd_taken)
  );

  tbp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .RST_VAL(LRST)) u_ltab (
    .clk(clk), .rst_n(rst_n), .rd_idx(pred_lhist), .rd_taken(pred_local),
    .wr_en(upd_valid), .wr_idx(upd_lhist), .wr_up(upd_taken)
  );

  // Chooser: counter high half selects global
  tbp_ctr_table #(.IDX_W(CHOOSE_W), .CNT_W(CCNT_W), .RST_VAL(CRST)) u_choose (
    .clk(clk), .rst_n(rst_n), .rd_idx(pred_cidx), .rd_taken(pred_use_global),
    .wr_en(chooser_train), .wr_idx(upd_cidx), .wr_up(global_was_right)
  );

  assign pred_taken = pred_use_global ? pred_global : pred_local;

  // R5: agreement leaves the selection for that branch unchanged
  assert_chooser_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !comp_disagree && pred_pc == upd_pc)
      |=> (!$stable(pred_pc) || $stable(pred_use_global)));
  // R5: a win for global keeps a global selection
  assert_chooser_toward_global_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chooser_train && global_was_right && pred_pc == upd_pc && pred_use_global)
      |=> (!$stable(pred_pc) || pred_use_global));
  // R5: a win for local keeps a local selection
  assert_chooser_toward_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chooser_train && !global_was_right && pred_pc == upd_pc && !pred_use_global)
      |=> (!$stable(pred_pc) || !pred_use_global));

endmodule

// File: tb/tournament_predictor_bench.sv
`timescale 1ns/1ps
module tournament_predictor_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_taken, pred_global, pred_local, pred_use_global;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0, upd_global_pred = 1'b0, upd_local_pred = 1'b0;

  always #10 clk = ~clk;

  tournament_predictor u_tournament_predictor (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_global(pred_global), .pred_local(pred_local), .pred_use_global(pred_use_global),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_global_pred(upd_global_pred), .upd_local_pred(upd_local_pred)
  );

  int nchecks = 0;
  int nfail = 0;
  bit done = 0;

  // Reference model
  int m_g [4096];
  int m_l [1024];
  int m_c [4096];
  int m_lh [1024];
  int m_gh;

  function automatic int bump(int v, bit up, int top);
    int r;
    r = up ? v + 1 : v - 1;
    if (r > top) r = top;
    if (r < 0) r = 0;
    return r;
  endfunction

  function automatic bit exp_global();
    return m_g[m_gh] > 1;
  endfunction
  function automatic bit exp_local(logic [31:0] pc);
    return m_l[m_lh[pc[11:2]]] > 3;
  endfunction
  function automatic bit exp_use_global(logic [31:0] pc);
    return m_c[pc[13:2]] > 1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4096; i++) begin m_g[i] = 1; m_c[i] = 1; end
    for (int i = 0; i < 1024; i++) begin m_l[i] = 3; m_lh[i] = 0; end
    m_gh = 0;
  endtask

  task automatic model_update(logic [31:0] pc, bit t, bit g, bit l);
    int li, h;
    li = int'(pc[11:2]);
    h = m_lh[li];
    m_g[m_gh] = bump(m_g[m_gh], t, 3);
    m_l[h] = bump(m_l[h], t, 7);
    if (g != l) m_c[pc[13:2]] = bump(m_c[pc[13:2]], g == t, 3);
    m_lh[li] = ((h * 2) + int'(t)) % 1024;
    m_gh = ((m_gh * 2) + int'(t)) % 4096;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // One cycle: drive after negedge, check before posedge, then advance model
  task automatic cyc(string pfx, logic [31:0] ppc, bit uv, logic [31:0] upc, bit ut, bit ug, bit ul);
    bit eg, el, eu;
    @(negedge clk);
    pred_pc = ppc; upd_valid = uv; upd_pc = upc;
    upd_taken = ut; upd_global_pred = ug; upd_local_pred = ul;
    #2;
    eg = exp_global(); el = exp_local(ppc); eu = exp_use_global(ppc);
    chk({pfx, " R2/R6/R7/R9 global"}, pred_global, eg);
    chk({pfx, " R3/R6/R8/R9 local"}, pred_local, el);
    chk({pfx, " R4/R5 chooser"}, pred_use_global, eu);
    chk({pfx, " R4/R10 final"}, pred_taken, eu ? eg : el);
    @(posedge clk);
    if (uv) model_update(upc, ut, ug, ul);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pred_pc = $urandom; #2;
      chk("R1 reset pred_taken", pred_taken, 1'b0);
      chk("R1 reset use_global", pred_use_global, 1'b0);
      chk("R1 reset global", pred_global, 1'b0);
      chk("R1 reset local", pred_local, 1'b0);
    end

    // R9: drive one branch taken until all counters saturate, then back down
    for (int i = 0; i < 20; i++) cyc("sat-up", 32'h0000_1040, 1, 32'h0000_1040, 1, 1, 0);
    for (int i = 0; i < 20; i++) cyc("sat-dn", 32'h0000_1040, 1, 32'h0000_1040, 0, 0, 1);

    // R5: disagreements steer the chooser both ways, agreements hold it
    for (int i = 0; i < 4; i++) cyc("R5 to-global", 32'h0000_2200, 1, 32'h0000_2200, 1, 1, 0);
    for (int i = 0; i < 4; i++) cyc("R5 agree", 32'h0000_2200, 1, 32'h0000_2200, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc("R5 to-local", 32'h0000_2200, 1, 32'h0000_2200, 0, 1, 0);

    // R11: garbage on the update inputs while valid is low
    for (int i = 0; i < 40; i++)
      cyc("R11 idle", 32'h0000_2200 ^ ($urandom & 32'h3c), 0, $urandom, 1'($urandom), 1'($urandom), 1'($urandom));

    // R8: two aliasing-free branches with opposite patterns
    for (int i = 0; i < 30; i++) begin
      cyc("R8 a", 32'h0000_0100, 1, 32'h0000_0100, 1, 1, 1);
      cyc("R8 b", 32'h0000_0100, 1, 32'h0000_0204, 0, 0, 0);
    end

    // Random traffic over a small branch pool
    for (int i = 0; i < 8; i++) pool[i] = $urandom & 32'h0000_fffc;
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] up, pp;
      bit t, g, l, v;
      up = pool[$urandom % 8];
      pp = ($urandom % 2 == 0) ? up : pool[$urandom % 8];
      t  = ((i % 5) != 4) ^ ($urandom % 11 == 0) ^ up[2];
      v  = ($urandom % 8 != 0);
      if ($urandom % 4 != 0) begin
        g = exp_global(); l = exp_local(up);
      end else begin
        g = 1'($urandom); l = 1'($urandom);
      end
      cyc("rand R10", pp, v, up, t, g, l);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

endmodule